// File: doc/BRIEF.md
# Configuration Write Holding Queue

This block sits behind a host-bus target and takes in configuration writes aimed at the local agent. It keeps exactly one of them: a 32-bit address, a 32-bit data word and its byte enables. It passes that write to an internal bus once the ordering logic allows it, and it keeps the completion status until the initiator has collected it. Two completion protocols share the one entry, and the protocol is chosen when a request is captured.

In delayed mode, the first attempt is captured and answered with retry. The initiator then repeats the request until its copy matches the stored entry after the internal write has finished. That matching repeat is answered with done and frees the entry. In split mode, the capture is answered with a split response. After the internal write is acknowledged, the block presents a completion message on a valid/ready port until that message is accepted. I/O writes are answered with a master abort. Configuration writes that carry the 64-bit request flag are rejected and raise an error pulse, so the internal transfer is never wider than 32 bits.

Top module: `cfgwr_queue`

## Requirements
- R1: After a synchronous active-high reset, the entry is empty, `ib_req`, `cmsg_valid` and `proto_err` are 0, and `tgt_resp` is NONE (code 0).
- R2: A request with command 4'h3 (I/O write) is answered one cycle later with MABORT (code 3). It is never captured, so no internal request follows from it.
- R3: A request with command 4'hB (configuration write) and `tgt_req64` high is answered one cycle later with MABORT and a one-cycle `proto_err` pulse. It is not captured.
- R4: A configuration write that arrives while the entry is empty is captured. It is answered one cycle later with RETRY (code 1) in delayed mode (`tgt_split`=0) or with SPLIT (code 4) in split mode (`tgt_split`=1).
- R5: `ib_req` rises only in the cycle after the entry was pending with `order_ok` high. It then stays high, with stable `ib_addr`/`ib_data`/`ib_be` equal to the captured request, until a cycle with `ib_ack` high.
- R6: In delayed mode, a repeat whose address, data and byte enables all equal the stored entry, arriving after the internal write was acknowledged, is answered with DONE (code 2). It frees the entry in the same cycle, so the next configuration write is captured.
- R7: While the entry is occupied, any configuration write that is not a completing delayed-mode match is answered with RETRY and leaves the stored request unchanged.
- R8: In split mode, `cmsg_valid` rises in the cycle after `ib_ack` is taken and carries the stored address on `cmsg_addr`. It holds until accepted with `cmsg_ready`, and the entry is then empty.
- R9: `tgt_split` is sampled only at capture. A later value on a repeat does not change the stored entry's protocol.
- R10: Any command other than 4'h3 and 4'hB is answered with NONE and has no effect on the entry.
- R11: A finished delayed-mode status is held for as long as the initiator takes to return; no time limit discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | A request is present this cycle |
| tgt_cmd | input | 4 | Bus command code |
| tgt_addr | input | AW | Request address |
| tgt_data | input | DW | Write data |
| tgt_be | input | DW/8 | Byte enables |
| tgt_req64 | input | 1 | Initiator asked for a 64-bit transfer |
| tgt_split | input | 1 | 1 = split protocol, 0 = delayed protocol |
| tgt_resp | output | 3 | Registered response: 0 NONE, 1 RETRY, 2 DONE, 3 MABORT, 4 SPLIT |
| proto_err | output | 1 | One-cycle pulse on a 64-bit configuration write |
| order_ok | input | 1 | Ordering permits issue of the pending write |
| ib_req | output | 1 | Internal write request |
| ib_addr | output | AW | Internal write address |
| ib_data | output | DW | Internal write data, always 32 bits |
| ib_be | output | DW/8 | Internal write byte enables |
| ib_ack | input | 1 | Internal bus accepted the write |
| cmsg_valid | output | 1 | Split completion message is available |
| cmsg_addr | output | AW | Address of the completed split write |
| cmsg_ready | input | 1 | Completion message accepted |

## Verification
The properties assume that the internal bus only raises `ib_ack` while `ib_req` is high, and that `cmsg_ready` is treated as meaningful only while `cmsg_valid` is high. The bench drives the acknowledge only against the request it observes, and it drives the ready line freely, since a ready without a valid message must be harmless. Requests are drawn from a small pool of addresses, data words and byte-enable patterns, so that exact repeats and near misses both occur often. Commands are weighted toward configuration writes, with I/O writes, 64-bit writes and unclaimed codes mixed in.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;
  localparam logic [3:0] CMD_IO_WR  = 4'h3;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  typedef enum logic [2:0] {
    RSP_NONE   = 3'd0,
    RSP_RETRY  = 3'd1,
    RSP_DONE   = 3'd2,
    RSP_MABORT = 3'd3,
    RSP_SPLIT  = 3'd4
  } rsp_t;

  typedef enum logic [1:0] {
    ST_EMPTY,
    ST_PEND,
    ST_ISSUED,
    ST_COMPLETE
  } st_t;

  typedef enum logic [1:0] {
    CLS_IGNORE,
    CLS_ABORT,
    CLS_BADWIDTH,
    CLS_CFGWR
  } cls_t;
endpackage

// File: rtl/cfgwr_decode.sv
module cfgwr_decode
  import cfgwr_pkg::*;
(
  input  logic       req_valid,
  input  logic [3:0] req_cmd,
  input  logic       req_wide,
  output cls_t       req_cls
);
  always_comb begin
    req_cls = CLS_IGNORE;
    if (req_valid) begin
      if (req_cmd == CMD_IO_WR) begin
        req_cls = CLS_ABORT;
      end else if (req_cmd == CMD_CFG_WR) begin
        req_cls = req_wide ? CLS_BADWIDTH : CLS_CFGWR;
      end
    end
  end
endmodule

// File: rtl/cfgwr_entry.sv
module cfgwr_entry #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           cap_en,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic [BEW-1:0] in_be,
  input  logic           in_split,
  output logic [AW-1:0]  st_addr,
  output logic [DW-1:0]  st_data,
  output logic [BEW-1:0] st_be,
  output logic           st_split,
  output logic           same_req
);
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [BEW-1:0] be_q;
  logic           split_q;

  // Holding registers carry no reset; the controller's state qualifies them.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= in_addr;
      data_q  <= in_data;
      be_q    <= in_be;
      split_q <= in_split;
    end
  end

  always_comb begin
    same_req = (in_addr == addr_q) && (in_data == data_q) && (in_be == be_q);
  end

  assign st_addr  = addr_q;
  assign st_data  = data_q;
  assign st_be    = be_q;
  assign st_split = split_q;
endmodule

// File: rtl/cfgwr_ctrl.sv
module cfgwr_ctrl
  import cfgwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cls_t       req_cls,
  input  logic       req_split,
  input  logic       same_req,
  input  logic       st_split,
  input  logic       order_ok,
  input  logic       ib_ack,
  input  logic       cmsg_ready,
  output logic       cap_en,
  output logic [2:0] resp_q,
  output logic       err_q,
  output logic       ib_req_q,
  output logic       cmsg_valid_q
);
  st_t  st_q, st_n;
  rsp_t rsp_n;
  logic err_n;
  logic split_n;

  always_comb begin
    st_n    = st_q;
    cap_en  = 1'b0;
    rsp_n   = RSP_NONE;
    err_n   = 1'b0;
    split_n = st_split;

    case (st_q)
      ST_PEND:     if (order_ok) st_n = ST_ISSUED;
      ST_ISSUED:   if (ib_ack) st_n = ST_COMPLETE;
      ST_COMPLETE: if (st_split && cmsg_ready) st_n = ST_EMPTY;
      default:     st_n = st_q;
    endcase

    case (req_cls)
      CLS_ABORT: rsp_n = RSP_MABORT;
      CLS_BADWIDTH: begin
        rsp_n = RSP_MABORT;
        err_n = 1'b1;
      end
      CLS_CFGWR: begin
        if (st_q == ST_EMPTY) begin
          cap_en  = 1'b1;
          st_n    = ST_PEND;
          split_n = req_split;
          rsp_n   = req_split ? RSP_SPLIT : RSP_RETRY;
        end else if (!st_split && st_q == ST_COMPLETE && same_req) begin
          rsp_n = RSP_DONE;
          st_n  = ST_EMPTY;
        end else begin
          rsp_n = RSP_RETRY;
        end
      end
      default: rsp_n = RSP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_EMPTY;
      resp_q       <= RSP_NONE;
      err_q        <= 1'b0;
      ib_req_q     <= 1'b0;
      cmsg_valid_q <= 1'b0;
    end else begin
      st_q         <= st_n;
      resp_q       <= rsp_n;
      err_q        <= err_n;
      ib_req_q     <= (st_n == ST_ISSUED);
      cmsg_valid_q <= (st_n == ST_COMPLETE) && split_n;
    end
  end
endmodule

// File: rtl/cfgwr_queue.sv
module cfgwr_queue
  import cfgwr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tgt_valid,
  input  logic [3:0]     tgt_cmd,
  input  logic [AW-1:0]  tgt_addr,
  input  logic [DW-1:0]  tgt_data,
  input  logic [BEW-1:0] tgt_be,
  input  logic           tgt_req64,
  input  logic           tgt_split,
  output logic [2:0]     tgt_resp,
  output logic           proto_err,
  input  logic           order_ok,
  output logic           ib_req,
  output logic [AW-1:0]  ib_addr,
  output logic [DW-1:0]  ib_data,
  output logic [BEW-1:0] ib_be,
  input  logic           ib_ack,
  output logic           cmsg_valid,
  output logic [AW-1:0]  cmsg_addr,
  input  logic           cmsg_ready
);
  cls_t           cls;
  logic           cap_en;
  logic           same_req;
  logic           st_split;
  logic [AW-1:0]  st_addr;
  logic [DW-1:0]  st_data;
  logic [BEW-1:0] st_be;

  cfgwr_decode u_decode (
    .req_valid (tgt_valid),
    .req_cmd   (tgt_cmd),
    .req_wide  (tgt_req64),
    .req_cls   (cls)
  );

  cfgwr_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk      (clk),
    .cap_en   (cap_en),
    .in_addr  (tgt_addr),
    .in_data  (tgt_data),
    .in_be    (tgt_be),
    .in_split (tgt_split),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .st_be    (st_be),
    .st_split (st_split),
    .same_req (same_req)
  );

  cfgwr_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_cls      (cls),
    .req_split    (tgt_split),
    .same_req     (same_req),
    .st_split     (st_split),
    .order_ok     (order_ok),
    .ib_ack       (ib_ack),
    .cmsg_ready   (cmsg_ready),
    .cap_en       (cap_en),
    .resp_q       (tgt_resp),
    .err_q        (proto_err),
    .ib_req_q     (ib_req),
    .cmsg_valid_q (cmsg_valid)
  );

  assign ib_addr   = st_addr;
  assign ib_data   = st_data;
  assign ib_be     = st_be;
  assign cmsg_addr = st_addr;
endmodule

// File: rtl/cfgwr_queue_chk.sv
module cfgwr_queue_chk
  import cfgwr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int BEW = DW / 8
) (
  input logic           clk,
  input logic           rst,
  input logic           tgt_valid,
  input logic [3:0]     tgt_cmd,
  input logic [AW-1:0]  tgt_addr,
  input logic [DW-1:0]  tgt_data,
  input logic [BEW-1:0] tgt_be,
  input logic           tgt_req64,
  input logic           tgt_split,
  input logic [2:0]     tgt_resp,
  input logic           proto_err,
  input logic           order_ok,
  input logic           ib_req,
  input logic [AW-1:0]  ib_addr,
  input logic [DW-1:0]  ib_data,
  input logic [BEW-1:0] ib_be,
  input logic           ib_ack,
  input logic           cmsg_valid,
  input logic [AW-1:0]  cmsg_addr,
  input logic           cmsg_ready
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!ib_req && !cmsg_valid && !proto_err && tgt_resp == RSP_NONE));

  // R2
  io_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && tgt_cmd == CMD_IO_WR) |=> (tgt_resp == RSP_MABORT && !proto_err));

  // R3
  wide_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && tgt_cmd == CMD_CFG_WR && tgt_req64) |=> (proto_err && tgt_resp == RSP_MABORT));

  // R5
  issue_permit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ib_req) |-> $past(order_ok));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_data) && $stable(ib_be)));

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmsg_valid && !cmsg_ready) |=> (cmsg_valid && $stable(cmsg_addr)));

  // R8
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !(ib_req && cmsg_valid));

  // R10
  unclaimed_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && tgt_cmd != CMD_IO_WR && tgt_cmd != CMD_CFG_WR) |=> (tgt_resp == RSP_NONE));
endmodule

bind cfgwr_queue cfgwr_queue_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/cfgwr_queue_test.sv
module cfgwr_queue_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tgt_valid = 1'b0;
  logic [3:0] tgt_cmd = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] tgt_data = '0;
  logic [BEW-1:0] tgt_be = '0;
  logic tgt_req64 = 1'b0;
  logic tgt_split = 1'b0;
  logic order_ok = 1'b0;
  logic ib_ack = 1'b0;
  logic cmsg_ready = 1'b0;
  logic [2:0] tgt_resp;
  logic proto_err, ib_req, cmsg_valid;
  logic [AW-1:0] ib_addr, cmsg_addr;
  logic [DW-1:0] ib_data;
  logic [BEW-1:0] ib_be;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // model state: 0 empty, 1 pending, 2 issued, 3 complete
  int m_st = 0;
  bit m_split = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic [BEW-1:0] m_be = '0;
  logic [2:0] e_resp = 3'd0;
  bit e_err = 0;
  string e_tag = "R1";

  cfgwr_queue #(.AW(AW), .DW(DW)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; e_resp = 3'd0; e_err = 0; e_tag = "R1";
  endtask

  // next model state from the current inputs, as the requirements define it
  task automatic model_step();
    int nst;
    nst = m_st;
    e_resp = 3'd0; e_err = 0; e_tag = "R10";
    if (m_st == 1 && order_ok) nst = 2;
    else if (m_st == 2 && ib_ack) nst = 3;
    else if (m_st == 3 && m_split && cmsg_ready) nst = 0;
    if (tgt_valid) begin
      if (tgt_cmd == 4'h3) begin
        e_resp = 3'd3; e_tag = "R2";
      end else if (tgt_cmd == 4'hB) begin
        if (tgt_req64) begin
          e_resp = 3'd3; e_err = 1; e_tag = "R3";
        end else if (m_st == 0) begin
          m_addr = tgt_addr; m_data = tgt_data; m_be = tgt_be; m_split = tgt_split;
          e_resp = tgt_split ? 3'd4 : 3'd1; e_tag = "R4";
          nst = 1;
        end else if (!m_split && m_st == 3 && tgt_addr == m_addr &&
                     tgt_data == m_data && tgt_be == m_be) begin
          e_resp = 3'd2; e_tag = "R6"; nst = 0;
        end else begin
          e_resp = 3'd1; e_tag = "R7";
        end
      end
    end
    m_st = nst;
  endtask

  task automatic compare();
    chk(e_tag, tgt_resp, e_resp);
    chk("R3 err", proto_err, e_err);
    chk("R5 req", ib_req, m_st == 2);
    chk("R8 msg", cmsg_valid, m_st == 3 && m_split);
    if (m_st == 2) begin
      chk("R5 addr", ib_addr, m_addr);
      chk("R7 data", ib_data, m_data);
      chk("R5 be", ib_be, m_be);
    end
    if (m_st == 3 && m_split) chk("R8 addr", cmsg_addr, m_addr);
  endtask

  // called at a falling edge; drives, advances one clock, checks
  task automatic cyc(input bit v, input logic [3:0] c, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [BEW-1:0] b, input bit w,
                     input bit s, input bit ok, input bit ak, input bit rd);
    tgt_valid = v; tgt_cmd = c; tgt_addr = a; tgt_data = d; tgt_be = b;
    tgt_req64 = w; tgt_split = s; order_ok = ok; ib_ack = ak; cmsg_ready = rd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input bit ok, input bit ak, input bit rd);
    for (int i = 0; i < n; i++) cyc(0, 4'h0, '0, '0, '0, 0, 0, ok, ak, rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1 reset state
    chk("R1 resp", tgt_resp, 3'd0);
    chk("R1 req", ib_req, 1'b0);
    chk("R1 msg", cmsg_valid, 1'b0);
    chk("R1 err", proto_err, 1'b0);

    // R2 I/O write aborts and nothing is issued
    cyc(1, 4'h3, 32'h100, 32'hAAAA, 4'hF, 0, 0, 1, 0, 0);
    idle(3, 1, 0, 0);
    // R3 wide configuration write rejected
    cyc(1, 4'hB, 32'h104, 32'h1234, 4'hF, 1, 0, 1, 0, 0);
    idle(2, 1, 0, 0);
    // R10 unclaimed command
    cyc(1, 4'h6, 32'h108, 32'h5555, 4'hF, 0, 0, 1, 0, 0);

    // R4 delayed capture, held pending without permit
    cyc(1, 4'hB, 32'h200, 32'hCAFE, 4'h3, 0, 0, 0, 0, 0);
    idle(3, 0, 0, 0);
    // R7 mismatch while occupied is refused
    cyc(1, 4'hB, 32'h200, 32'hCAFF, 4'h3, 0, 0, 0, 0, 0);
    cyc(1, 4'hB, 32'h200, 32'hCAFE, 4'h3, 0, 0, 0, 0, 0);
    idle(1, 1, 0, 0);
    idle(3, 1, 0, 0);
    idle(1, 0, 1, 0);
    // R11 status held over a long gap
    idle(40, 1, 0, 1);
    // R9 repeat with the other mode value still completes as delayed
    cyc(1, 4'hB, 32'h200, 32'hCAFE, 4'h3, 0, 1, 0, 0, 0);
    chk("R9 done", tgt_resp, 3'd2);
    // R6 entry freed: a new write is captured at once
    cyc(1, 4'hB, 32'h300, 32'hBEEF, 4'hF, 0, 1, 1, 0, 0);
    chk("R6 recapture", tgt_resp, 3'd4);
    idle(1, 1, 0, 0);
    idle(1, 0, 1, 0);
    // R8 message held without ready, then accepted
    idle(4, 0, 0, 0);
    idle(1, 0, 0, 1);
    cyc(1, 4'hB, 32'h400, 32'h1, 4'h1, 0, 0, 0, 0, 0);
    chk("R8 empty after accept", tgt_resp, 3'd1);
    idle(1, 1, 0, 0);
    idle(1, 0, 1, 0);
    cyc(1, 4'hB, 32'h400, 32'h1, 4'h1, 0, 0, 0, 0, 0);

    // random phase
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [3:0] c;
      r = $urandom_range(0, 9);
      c = (r < 6) ? 4'hB : (r == 6) ? 4'h3 : (r == 7) ? 4'h7 : 4'hB;
      cyc($urandom_range(0, 1), c, AW'($urandom_range(0, 1) * 4),
          DW'($urandom_range(0, 1)), BEW'($urandom_range(0, 1) ? 4'hF : 4'h1),
          ($urandom_range(0, 15) == 0), $urandom_range(0, 1),
          $urandom_range(0, 1), ib_req && ($urandom_range(0, 2) == 0),
          $urandom_range(0, 1));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule